// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block lets two peers raise interrupts in each other through a byte-wide message channel. Software on the local side reaches it through a simple register port with an 8-bit offset, an access-size field and 32-bit read and write data. Two 16-bit registers set the local interrupt: an enable mask and a status word. One level interrupt line is driven from them. Writing a byte to the doorbell offset sends that byte to the remote peer. Every byte that arrives from the remote peer replaces the status word, so the byte value can carry a reason code.

A register access is presented for one cycle with `req_valid`. Read data is combinational and valid in that same cycle. Register updates take effect at the clock edge that ends the access.

The port decoder sorts each access into one of these kinds:
- ACC_IDLE: no access.
- ACC_MASK_WR: mask write.
- ACC_STAT_WR: status write.
- ACC_MASK_RD: mask read.
- ACC_STAT_RD: status read.
- ACC_BELL: doorbell write.
- ACC_NULL: any access that has no effect.

The outbound channel is a small state machine with two states, TX_IDLE and TX_PEND:
- The *ring* transition goes from TX_IDLE to TX_PEND on a doorbell write and latches the byte.
- The *drain* transition goes from TX_PEND back to TX_IDLE when the receiver raises `tx_ready`.
- A doorbell write taken in TX_PEND is a *drop*. The machine stays in TX_PEND and the overflow flag is set.

Top module: `bell_regs`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the block clears mask, status, `irq`, `tx_valid` and `tx_overflow` to zero.
- R2: `irq` is a register. After each edge it equals the OR-reduction of (status AND mask), using the values those registers hold after that edge.
- R3: Access size is encoded on `req_size` as 0 = byte, 1 = halfword and 2 or 3 = word. A halfword write ignores address bit 0. A halfword write at offset 0x00/0x01 loads the mask from `req_wdata[15:0]`, and one at offset 0x10/0x11 loads the status. A halfword write at any other offset changes nothing.
- R4: A halfword read at offset 0x00 returns the mask, zero-extended to 32 bits. A halfword read at offset 0x10 returns the status and clears the status at the end of that access.
- R5: A byte write at offset 0x20, taken while no byte is pending, puts `req_wdata[7:0]` on `tx_data`. `tx_valid` is high from the next cycle. `tx_valid` and `tx_data` hold until a cycle in which `tx_ready` is high.
- R6: These accesses have no effect on any register and return read data zero: byte writes to offsets other than 0x20, all word accesses, all byte reads, and halfword reads at any offset other than exactly 0x00 or 0x10.
- R7: A doorbell write taken while a byte is pending is dropped. This includes a cycle in which the pending byte is being drained. The dropped write leaves `tx_data` unchanged and sets `tx_overflow`, which stays high until reset.
- R8: Each cycle in which `rx_valid` is high, the status becomes `{8'h00, rx_data}`, replacing its old contents.
- R9: When `rx_valid` coincides with a status read or a status write, the received byte wins. The status takes the received byte, not zero and not the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 8 | Byte offset within the register window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Outbound byte pending |
| tx_data | output | 8 | Outbound byte |
| tx_ready | input | 1 | Receiver accepts the outbound byte |
| rx_valid | input | 1 | Inbound byte present |
| rx_data | input | 8 | Inbound byte |
| irq | output | 1 | Level interrupt |
| tx_overflow | output | 1 | Sticky flag: a doorbell write was dropped |

## Verification
The bench targets three kinds of corner case. The first is address bit 0: a design that masked it on reads would return the mask at offset 0x01, and one that honoured it on writes would ignore a status write at 0x11. The second is the collision of an inbound byte with a status read or write. A design that let the bus win would lose a remote interrupt, leaving `irq` low and the status zero. The third is a doorbell write while a byte is pending, including the drain cycle. A wrong design would overwrite `tx_data` or emit a second byte, and would never raise the overflow flag. Random traffic mixes all size and offset pairs with inbound bytes and back-pressure, and checks `irq` after every edge.

// File: rtl/bell_pkg.sv
package bell_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_MASK_WR,
        ACC_STAT_WR,
        ACC_MASK_RD,
        ACC_STAT_RD,
        ACC_BELL,
        ACC_NULL
    } acc_e;

    typedef enum logic {
        TX_IDLE,
        TX_PEND
    } tx_e;

endpackage

// File: rtl/bell_decode.sv
module bell_decode
    import bell_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int MASK_OFS = 0,
    parameter int STAT_OFS = 16,
    parameter int BELL_OFS = 32
) (
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    output acc_e              kind
);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] BELL_A = ADDR_W'(BELL_OFS);

    logic [ADDR_W-1:0] even_addr;
    size_e             sz;

    assign even_addr = {req_addr[ADDR_W-1:1], 1'b0};
    assign sz        = size_e'(req_size);

    always_comb begin
        kind = ACC_IDLE;
        if (req_valid) begin
            kind = ACC_NULL;
            unique case (sz)
                SZ_HALF: begin
                    if (req_wr) begin
                        if (even_addr == MASK_A)      kind = ACC_MASK_WR;
                        else if (even_addr == STAT_A) kind = ACC_STAT_WR;
                    end else begin
                        if (req_addr == MASK_A)       kind = ACC_MASK_RD;
                        else if (req_addr == STAT_A)  kind = ACC_STAT_RD;
                    end
                end
                SZ_BYTE: begin
                    if (req_wr && req_addr == BELL_A) kind = ACC_BELL;
                end
                default: kind = ACC_NULL;
            endcase
        end
    end
endmodule

// File: rtl/bell_core.sv
module bell_core
    import bell_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 16,
    parameter int MSG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_e              kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_valid,
    input  logic [MSG_W-1:0]  rx_data,
    output logic [DATA_W-1:0] rdata,
    output logic [REG_W-1:0]  mask_q,
    output logic [REG_W-1:0]  stat_q,
    output logic              irq_q
);
    logic [REG_W-1:0] mask_d;
    logic [REG_W-1:0] stat_d;

    always_comb begin
        mask_d = mask_q;
        stat_d = stat_q;
        if (kind == ACC_MASK_WR) mask_d = wdata[REG_W-1:0];
        if (rx_valid) begin
            stat_d = REG_W'(rx_data);
        end else if (kind == ACC_STAT_WR) begin
            stat_d = wdata[REG_W-1:0];
        end else if (kind == ACC_STAT_RD) begin
            stat_d = '0;
        end
    end

    always_comb begin
        rdata = '0;
        if (kind == ACC_MASK_RD)      rdata = DATA_W'(mask_q);
        else if (kind == ACC_STAT_RD) rdata = DATA_W'(stat_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            stat_q <= stat_d;
            irq_q  <= |(mask_d & stat_d);
        end
    end
endmodule

// File: rtl/bell_tx.sv
module bell_tx
    import bell_pkg::*;
#(
    parameter int MSG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ring,
    input  logic [MSG_W-1:0] ring_data,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [MSG_W-1:0] tx_data,
    output logic             overflow
);
    tx_e              state_q, state_d;
    logic [MSG_W-1:0] data_q;
    logic             ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            data_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_IDLE && ring) data_q <= ring_data;
            if (state_q == TX_PEND && ring) ovf_q  <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (ring)     state_d = TX_PEND;
            TX_PEND: if (tx_ready) state_d = TX_IDLE;
            default:               state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_valid = (state_q == TX_PEND);
        tx_data  = data_q;
        overflow = ovf_q;
    end
endmodule

// File: rtl/bell_regs.sv
module bell_regs
    import bell_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int REG_W    = 16,
    parameter int MSG_W    = 8,
    parameter int MASK_OFS = 0,
    parameter int STAT_OFS = 16,
    parameter int BELL_OFS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              tx_valid,
    output logic [MSG_W-1:0]  tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [MSG_W-1:0]  rx_data,
    output logic              irq,
    output logic              tx_overflow
);
    acc_e             kind;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] stat_q;

    bell_decode #(
        .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS),
        .STAT_OFS(STAT_OFS), .BELL_OFS(BELL_OFS)
    ) u_dec (
        .req_valid(req_valid), .req_wr(req_wr), .req_size(req_size),
        .req_addr(req_addr), .kind(kind)
    );

    bell_core #(.DATA_W(DATA_W), .REG_W(REG_W), .MSG_W(MSG_W)) u_core (
        .clk(clk), .rst(rst), .kind(kind), .wdata(req_wdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rdata(rsp_rdata),
        .mask_q(mask_q), .stat_q(stat_q), .irq_q(irq)
    );

    bell_tx #(.MSG_W(MSG_W)) u_tx (
        .clk(clk), .rst(rst), .ring(kind == ACC_BELL),
        .ring_data(req_wdata[MSG_W-1:0]), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .overflow(tx_overflow)
    );
endmodule

// File: rtl/bell_chk.sv
module bell_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int REG_W    = 16,
    parameter int MSG_W    = 8,
    parameter int STAT_OFS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_wr,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              tx_valid,
    input logic [MSG_W-1:0]  tx_data,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic [MSG_W-1:0]  rx_data,
    input logic              irq,
    input logic              tx_overflow,
    input logic [REG_W-1:0]  mask_q,
    input logic [REG_W-1:0]  stat_q
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!irq && !tx_valid && !tx_overflow && mask_q == '0 && stat_q == '0));

    assert_irq_level_R2: assert property (@(posedge clk) disable iff (rst)
        irq == |(stat_q & mask_q));

    assert_read_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_wr && req_size == 2'd1 && req_addr == STAT_A && !rx_valid)
        |=> stat_q == '0);

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_null_read_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_wr && req_size != 2'd1) |-> rsp_rdata == '0);

    assert_word_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size[1]) |=> $stable(mask_q));

    assert_no_overflow_clear_R7: assert property (@(posedge clk) disable iff (rst)
        tx_overflow |=> tx_overflow);

    assert_rx_load_R8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> stat_q == REG_W'($past(rx_data)));
endmodule

bind bell_regs bell_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
    .MSG_W(MSG_W), .STAT_OFS(STAT_OFS)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr),
    .req_size(req_size), .req_addr(req_addr), .rsp_rdata(rsp_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .irq(irq),
    .tx_overflow(tx_overflow), .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/tb_bell_regs.sv
module tb_bell_regs;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_wr = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [7:0]  req_addr = 8'd0;
    logic [31:0] req_wdata = 32'd0;
    logic [31:0] rsp_rdata;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'd0;
    logic        irq, tx_overflow;

    bell_regs dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .irq(irq), .tx_overflow(tx_overflow)
    );

    always #(CLK_NS/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    logic [15:0] m_mask, m_stat;
    logic        m_pend, m_ovf;
    logic [7:0]  m_txd;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic v, logic w, logic [1:0] sz, logic [7:0] a);
        if (!v || w || sz != 2'd1) return 32'd0;
        if (a == 8'd0)  return {16'd0, m_mask};
        if (a == 8'd16) return {16'd0, m_stat};
        return 32'd0;
    endfunction

    task automatic cyc(input string tag, input logic v, input logic w, input logic [1:0] sz,
                       input logic [7:0] a, input logic [31:0] wd,
                       input logic rv, input logic [7:0] rd, input logic rdy);
        logic bell, hw;
        @(negedge clk);
        req_valid = v; req_wr = w; req_size = sz; req_addr = a; req_wdata = wd;
        rx_valid = rv; rx_data = rd; tx_ready = rdy;
        #1;
        chk(tag, rsp_rdata, exp_read(v, w, sz, a));
        bell = v && w && sz == 2'd0 && a == 8'd32;
        hw   = v && w && sz == 2'd1;
        if (bell && m_pend) m_ovf = 1'b1;
        if (m_pend) begin
            if (rdy) m_pend = 1'b0;
        end else if (bell) begin
            m_pend = 1'b1;
            m_txd  = wd[7:0];
        end
        if (hw && a[7:1] == 7'd0) m_mask = wd[15:0];
        if (rv) m_stat = {8'd0, rd};
        else if (hw && a[7:1] == 7'd8) m_stat = wd[15:0];
        else if (v && !w && sz == 2'd1 && a == 8'd16) m_stat = 16'd0;
        @(posedge clk); #1;
        chk("R2 irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
        chk("R5 tx_valid", {31'd0, tx_valid}, {31'd0, m_pend});
        if (m_pend) chk("R5 tx_data", {24'd0, tx_data}, {24'd0, m_txd});
        chk("R7 overflow", {31'd0, tx_overflow}, {31'd0, m_ovf});
    endtask

    task automatic idle(input string tag);
        cyc(tag, 1'b0, 1'b0, 2'd0, 8'd0, 32'd0, 1'b0, 8'd0, 1'b0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_mask = 16'd0; m_stat = 16'd0; m_pend = 1'b0; m_ovf = 1'b0; m_txd = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset values at the ports
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        chk("R1 overflow", {31'd0, tx_overflow}, 32'd0);
        cyc("R1 mask", 1'b1, 1'b0, 2'd1, 8'd0, 32'd0, 1'b0, 8'd0, 1'b0);
        cyc("R1 stat", 1'b1, 1'b0, 2'd1, 8'd16, 32'd0, 1'b0, 8'd0, 1'b0);

        // R3: halfword writes with bit 0 set
        cyc("R3 wr mask", 1'b1, 1'b1, 2'd1, 8'd1, 32'hABCD_00F0, 1'b0, 8'd0, 1'b0);
        cyc("R3 rd mask", 1'b1, 1'b0, 2'd1, 8'd0, 32'd0, 1'b0, 8'd0, 1'b0);
        cyc("R3 wr stat", 1'b1, 1'b1, 2'd1, 8'd17, 32'h0000_0030, 1'b0, 8'd0, 1'b0);
        cyc("R3 wr other", 1'b1, 1'b1, 2'd1, 8'd48, 32'hFFFF_FFFF, 1'b0, 8'd0, 1'b0);
        // R4: read returns value then clears
        cyc("R4 rd stat", 1'b1, 1'b0, 2'd1, 8'd16, 32'd0, 1'b0, 8'd0, 1'b0);
        cyc("R4 rd cleared", 1'b1, 1'b0, 2'd1, 8'd16, 32'd0, 1'b0, 8'd0, 1'b0);
        // R6: ignored accesses
        cyc("R6 word wr", 1'b1, 1'b1, 2'd2, 8'd0, 32'h0000_FFFF, 1'b0, 8'd0, 1'b0);
        cyc("R6 byte rd", 1'b1, 1'b0, 2'd0, 8'd0, 32'd0, 1'b0, 8'd0, 1'b0);
        cyc("R6 hw rd odd", 1'b1, 1'b0, 2'd1, 8'd1, 32'd0, 1'b0, 8'd0, 1'b0);
        cyc("R6 word rd", 1'b1, 1'b0, 2'd3, 8'd16, 32'd0, 1'b0, 8'd0, 1'b0);
        cyc("R6 byte wr 33", 1'b1, 1'b1, 2'd0, 8'd33, 32'h55, 1'b0, 8'd0, 1'b0);
        cyc("R6 mask kept", 1'b1, 1'b0, 2'd1, 8'd0, 32'd0, 1'b0, 8'd0, 1'b0);
        // R8: inbound byte overwrites status
        cyc("R8 rx", 1'b0, 1'b0, 2'd0, 8'd0, 32'd0, 1'b1, 8'hF3, 1'b0);
        cyc("R8 rd", 1'b1, 1'b0, 2'd1, 8'd16, 32'd0, 1'b0, 8'd0, 1'b0);
        // R9: inbound byte beats read clear and write
        cyc("R9 rx vs rd", 1'b0, 1'b0, 2'd0, 8'd0, 32'd0, 1'b1, 8'h10, 1'b0);
        cyc("R9 rd+rx", 1'b1, 1'b0, 2'd1, 8'd16, 32'd0, 1'b1, 8'h20, 1'b0);
        cyc("R9 rd after", 1'b1, 1'b0, 2'd1, 8'd16, 32'd0, 1'b0, 8'd0, 1'b0);
        cyc("R9 wr+rx", 1'b1, 1'b1, 2'd1, 8'd16, 32'h0000_FFFF, 1'b1, 8'h40, 1'b0);
        cyc("R9 rd after wr", 1'b1, 1'b0, 2'd1, 8'd16, 32'd0, 1'b0, 8'd0, 1'b0);
        // R5 / R7: doorbell, hold, drop during pend and during drain
        cyc("R5 bell", 1'b1, 1'b1, 2'd0, 8'd32, 32'h1234_5677, 1'b0, 8'd0, 1'b0);
        idle("R5 hold");
        cyc("R7 drop", 1'b1, 1'b1, 2'd0, 8'd32, 32'h0000_0099, 1'b0, 8'd0, 1'b0);
        cyc("R7 drop drain", 1'b1, 1'b1, 2'd0, 8'd32, 32'h0000_00AA, 1'b0, 8'd0, 1'b1);
        cyc("R5 bell again", 1'b1, 1'b1, 2'd0, 8'd32, 32'h0000_00BB, 1'b0, 8'd0, 1'b1);
        cyc("R5 drain", 1'b0, 1'b0, 2'd0, 8'd0, 32'd0, 1'b0, 8'd0, 1'b1);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            logic [1:0] sz;
            if (i == 2000) begin
                @(negedge clk); rst = 1'b1;
                @(negedge clk); rst = 1'b0;
                m_mask = 16'd0; m_stat = 16'd0; m_pend = 1'b0; m_ovf = 1'b0;
                #1;
                chk("R1 mid irq", {31'd0, irq}, 32'd0);
                chk("R1 mid ovf", {31'd0, tx_overflow}, 32'd0);
            end
            case ($urandom % 8)
                0: a = 8'd0;  1: a = 8'd1;  2: a = 8'd16; 3: a = 8'd17;
                4: a = 8'd32; 5: a = 8'd32; 6: a = 8'd33;
                default: a = 8'($urandom);
            endcase
            sz = ($urandom % 3 == 0) ? 2'($urandom) : (a == 8'd32 ? 2'd0 : 2'd1);
            cyc("R4 R6 rnd", ($urandom % 4) != 0, 1'($urandom), sz, a, $urandom,
                ($urandom % 5) == 0, 8'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule